// File: doc/BRIEF.md
# Single-Wire Slave Register Interface

This block is the slave end of a host-driven, open-drain, one-wire serial bus. The host talks to it with ordinary asynchronous byte frames, so a standard UART or a software-toggled pin can act as master. The block filters and oversamples the shared line and collects bytes. It reads a two-byte instruction that names an operation, a device, a bank, a byte count and a starting offset. It then stores incoming bytes, or returns register contents with an optional CRC byte at the end. It drives the wire only to pull it low while it returns data.

Two slaves with different `DEV_ADDR` values can share one wire. Bank 1 holds control and status. Bank 2 holds the secret-select byte, the 32-bit challenge and the read-only authentication code that comes from a neighbouring engine. Bank 3 is locked unless the test-mode input is high. Once the bus has been quiet for long enough, the block raises a sleep request. A control bit enables this request.

Top module: `swire_slave`

## Requirements
- R1: A byte frame is one low start bit, eight data bits with the LSB first, and one high stop bit. Each bit lasts `OVS` clock cycles and is sampled in the middle of the bit.
- R2: The first instruction byte holds the opcode in bits [7:6], the device select in bit [5], the bank in bits [4:3] and the byte count minus one in bits [2:0]. The second byte is the starting register offset.
- R3: Opcode 00 writes the following N data bytes to consecutive offsets, starting at the given offset.
- R4: Opcode 01 returns N bytes from consecutive offsets. Each byte is sent as a frame that is preceded by one idle bit time. The block drives the wire only by pulling it low through `pull_low`.
- R5: Opcode 10 works like opcode 01 and then sends one more byte. That byte is the CRC-8 of the returned bytes, using polynomial 0x07, initial value 0x00 and MSB-first processing.
- R6: If the device-select bit differs from `DEV_ADDR`, the block writes nothing and never drives the wire. It skips the data bytes of that transaction, including the CRC byte of an opcode-10 read, so that the next instruction is decoded correctly.
- R7: Register map:
  - Bank 1, offset 0 is control. Bit 0 enables auto-sleep. Writing a 1 to bit 7 performs a soft reset.
  - Bank 1, offset 1 is status. Bit 0 is the bus-error flag.
  - Bank 2, offset 0 is the secret select.
  - Bank 2, offsets 1 to 4 are the challenge bytes, least significant byte first.
  - Bank 2, offset 5 returns `auth_code` and ignores writes.
  - Unmapped locations, and all of bank 0, read as 0x00 and ignore writes.
- R8: While `test_mode` is low, any access to bank 3 sets the bus error, stores nothing and returns nothing. While `test_mode` is high, bank 3 reads as 0x00 and no error is set.
- R9: The bus-error flag stays set until the status register is read. That read returns the flag as 1 and clears it.
- R10: `sleep_req` rises after `IDLE_TO` cycles with no bus activity, but only while auto-sleep is enabled. Any activity drops it, and it stays low while auto-sleep is disabled.
- R11: Auto-sleep is enabled after reset and after a soft reset. A soft reset also clears the bank 2 registers and the bus error.
- R12: A low pulse on the line that is shorter than `DGL` cycles has no effect.
- R13: After reset, `pull_low` and `sleep_req` are low, and `sec_sel` and `challenge` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock running at `OVS` times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level sensed on the shared wire |
| test_mode | input | 1 | Unlocks bank 3 |
| auth_code | input | 8 | Authentication byte read at bank 2, offset 5 |
| pull_low | output | 1 | Open-drain enable; 1 pulls the wire low |
| sleep_req | output | 1 | Request to enter sleep |
| sec_sel | output | 8 | Secret-select register |
| challenge | output | 32 | Challenge register, offset 1 in bits [7:0] |

## Verification
The hardest case to reach is a transaction addressed to the other device. The block must stay silent and still count the bytes that belong to the other device, so that it stays aligned for the next instruction. The bench plays both the host and the absent second slave. It sends a foreign write and then a foreign read, supplying the bytes the other slave would have returned itself. It then checks that this block never pulled the line and that its next read returns the unchanged register. Sleep behaviour is driven from the same ports: long quiet gaps, a sub-threshold glitch, and writes to the control register.

// File: rtl/swire_slave.sv
module swire_slave #(
  parameter int OVS      = 16,
  parameter int DGL      = 3,
  parameter int IDLE_TO  = 4096,
  parameter bit DEV_ADDR = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        line_in,
  input  logic        test_mode,
  input  logic [7:0]  auth_code,
  output logic        pull_low,
  output logic        sleep_req,
  output logic [7:0]  sec_sel,
  output logic [31:0] challenge
);
  localparam int TW = $clog2(OVS);
  localparam int DW = $clog2(DGL + 1);
  localparam int IW = $clog2(IDLE_TO + 1);

  typedef enum logic [2:0] {T_OP, T_ADDR, T_WDATA, T_SKIP, T_TX} tst_t;
  tst_t tstate;

  function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  logic s1, s2, line_f;
  logic [DW-1:0] dg_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; line_f <= 1'b1; dg_cnt <= '0;
    end else begin
      s1 <= line_in; s2 <= s1;
      if (s2 == line_f) dg_cnt <= '0;
      else if (dg_cnt == DW'(DGL - 1)) begin line_f <= s2; dg_cnt <= '0; end
      else dg_cnt <= dg_cnt + 1'b1;
    end

  logic rx_busy, rx_valid;
  logic [TW-1:0] rx_tick;
  logic [3:0] rx_bit;
  logic [7:0] rx_sh;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0; rx_valid <= 1'b0; rx_tick <= '0; rx_bit <= '0; rx_sh <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (tstate == T_TX) rx_busy <= 1'b0;
      else if (!rx_busy) begin
        if (!line_f) begin rx_busy <= 1'b1; rx_tick <= TW'(OVS/2 - 1); rx_bit <= '0; end
      end else if (rx_tick != '0) rx_tick <= rx_tick - 1'b1;
      else begin
        rx_tick <= TW'(OVS - 1);
        rx_bit  <= rx_bit + 1'b1;
        if (rx_bit == 4'd0) begin if (line_f) rx_busy <= 1'b0; end
        else if (rx_bit < 4'd9) rx_sh <= {line_f, rx_sh[7:1]};
        else begin rx_busy <= 1'b0; rx_valid <= line_f; end
      end
    end

  logic tx_busy, tx_done, tx_load;
  logic [10:0] tx_sh;
  logic [TW-1:0] tx_tick;
  logic [3:0] tx_bit;
  logic [7:0] tx_data;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_done <= 1'b0; tx_sh <= '1; tx_tick <= '0; tx_bit <= '0;
    end else begin
      tx_done <= 1'b0;
      if (tx_load) begin
        tx_busy <= 1'b1; tx_sh <= {1'b1, tx_data, 1'b0, 1'b1};
        tx_tick <= TW'(OVS - 1); tx_bit <= '0;
      end else if (tx_busy) begin
        if (tx_tick != '0) tx_tick <= tx_tick - 1'b1;
        else begin
          tx_tick <= TW'(OVS - 1);
          tx_sh   <= {1'b1, tx_sh[10:1]};
          if (tx_bit == 4'd10) begin tx_busy <= 1'b0; tx_done <= 1'b1; end
          else tx_bit <= tx_bit + 1'b1;
        end
      end
    end
  assign pull_low = tx_busy & ~tx_sh[0];

  logic [7:0] ins_hi, ptr, ctrl, crc, rd_off, rd_data;
  logic [1:0] bank_q, rd_bank;
  logic [3:0] cnt;
  logic crc_mode, crc_sent, err, from_rd;
  logic [IW-1:0] idle_cnt;
  wire [1:0] i_op   = ins_hi[7:6];
  wire [1:0] i_bank = ins_hi[4:3];
  wire [2:0] i_cnt  = ins_hi[2:0];
  wire sel_ok = (ins_hi[5] == DEV_ADDR);
  wire bad    = (i_op == 2'd3) || (i_bank == 2'd3 && !test_mode);
  wire st_rd  = from_rd && rd_bank == 2'd1 && rd_off == 8'd1;

  assign rd_bank = (tstate == T_ADDR) ? i_bank : bank_q;
  assign rd_off  = (tstate == T_ADDR) ? rx_sh : ptr + 8'd1;

  always_comb begin
    rd_data = 8'h00;
    if (rd_bank == 2'd1) begin
      if (rd_off == 8'd0) rd_data = ctrl;
      else if (rd_off == 8'd1) rd_data = {7'b0, err};
    end else if (rd_bank == 2'd2) begin
      case (rd_off)
        8'd0: rd_data = sec_sel;
        8'd1: rd_data = challenge[7:0];
        8'd2: rd_data = challenge[15:8];
        8'd3: rd_data = challenge[23:16];
        8'd4: rd_data = challenge[31:24];
        8'd5: rd_data = auth_code;
        default: rd_data = 8'h00;
      endcase
    end
  end

  always_comb begin
    tx_load = 1'b0; from_rd = 1'b0; tx_data = rd_data;
    if (rx_valid && tstate == T_ADDR && sel_ok && !bad && i_op != 2'd0) begin
      tx_load = 1'b1; from_rd = 1'b1;
    end else if (tx_done && tstate == T_TX) begin
      if (cnt != 4'd0) begin tx_load = 1'b1; from_rd = 1'b1; end
      else if (crc_mode && !crc_sent) begin tx_load = 1'b1; tx_data = crc; end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tstate <= T_OP; ins_hi <= '0; bank_q <= '0; ptr <= '0; cnt <= '0; crc <= '0;
      crc_mode <= 1'b0; crc_sent <= 1'b0; ctrl <= 8'h01; err <= 1'b0;
      sec_sel <= '0; challenge <= '0;
    end else begin
      if (st_rd) err <= 1'b0;
      if (from_rd) crc <= crc_upd((tstate == T_ADDR) ? 8'h00 : crc, tx_data);
      case (tstate)
        T_OP: if (rx_valid) begin ins_hi <= rx_sh; tstate <= T_ADDR; end
        T_ADDR: if (rx_valid) begin
          ptr <= rx_sh; bank_q <= i_bank; cnt <= {1'b0, i_cnt};
          crc_mode <= (i_op == 2'd2); crc_sent <= 1'b0;
          if (!sel_ok) begin
            cnt <= {1'b0, i_cnt} + {3'b0, (i_op == 2'd2)};
            tstate <= (i_op == 2'd3) ? T_OP : T_SKIP;
          end else if (bad) begin
            err <= 1'b1;
            tstate <= (i_op == 2'd0) ? T_SKIP : T_OP;
          end else tstate <= (i_op == 2'd0) ? T_WDATA : T_TX;
        end
        T_WDATA, T_SKIP: if (rx_valid) begin
          if (cnt == 4'd0) tstate <= T_OP; else cnt <= cnt - 1'b1;
        end
        T_TX: if (tx_done) begin
          if (cnt != 4'd0) begin cnt <= cnt - 1'b1; ptr <= ptr + 8'd1; end
          else if (crc_mode && !crc_sent) crc_sent <= 1'b1;
          else tstate <= T_OP;
        end
        default: tstate <= T_OP;
      endcase
      if (rx_valid && tstate == T_WDATA) begin
        ptr <= ptr + 8'd1;
        if (bank_q == 2'd1 && ptr == 8'd0) begin
          if (rx_sh[7]) begin
            ctrl <= 8'h01; err <= 1'b0; sec_sel <= '0; challenge <= '0;
          end else ctrl <= rx_sh;
        end else if (bank_q == 2'd2) begin
          case (ptr)
            8'd0: sec_sel <= rx_sh;
            8'd1: challenge[7:0]   <= rx_sh;
            8'd2: challenge[15:8]  <= rx_sh;
            8'd3: challenge[23:16] <= rx_sh;
            8'd4: challenge[31:24] <= rx_sh;
            default: ;
          endcase
        end
      end
      if (idle_cnt == IW'(IDLE_TO)) tstate <= T_OP;
    end

  wire active = !line_f || rx_busy || tx_busy || tstate == T_TX;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) idle_cnt <= '0;
    else if (active) idle_cnt <= '0;
    else if (idle_cnt != IW'(IDLE_TO)) idle_cnt <= idle_cnt + 1'b1;
  assign sleep_req = ctrl[0] && idle_cnt == IW'(IDLE_TO);

  p_drive_in_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pull_low |-> tstate == T_TX);
  p_no_rx_in_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tstate == T_TX |-> !rx_valid);
  p_bank3_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && tstate == T_ADDR && sel_ok && i_bank == 2'd3 && !test_mode) |=> err);
  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> !err);
  p_glitch_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (line_f != $past(line_f)) |-> ($past(s2) == line_f));
  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |-> (!pull_low && !rx_busy));
endmodule

// File: tb/swire_slave_tb.sv
module swire_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVS = 16;
  localparam int IDLE_TO = 4096;
  localparam logic [7:0] AUTH = 8'h9E;

  logic clk = 1'b0, rst_n = 1'b0, host_drv = 1'b1, test_mode = 1'b0;
  logic pull_low, sleep_req;
  logic [7:0] sec_sel;
  logic [31:0] challenge;
  wire line = host_drv & ~pull_low;
  int n_chk = 0, n_err = 0, drv_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (pull_low) drv_cnt++;

  swire_slave u_dut (.clk(clk), .rst_n(rst_n), .line_in(line), .test_mode(test_mode),
    .auth_code(AUTH), .pull_low(pull_low), .sleep_req(sleep_req),
    .sec_sel(sec_sel), .challenge(challenge));

  // {bank, offset, write value, expected read}
  localparam logic [25:0] VEC [6] = '{
    {2'd2, 8'd0, 8'h5A, 8'h5A},
    {2'd2, 8'd3, 8'hC3, 8'hC3},
    {2'd2, 8'd5, 8'h77, AUTH},
    {2'd1, 8'd0, 8'h41, 8'h41},
    {2'd0, 8'd2, 8'h33, 8'h00},
    {2'd2, 8'd7, 8'h11, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    host_drv = 1'b0; repeat (OVS) @(negedge clk);
    for (int i = 0; i < 8; i++) begin host_drv = b[i]; repeat (OVS) @(negedge clk); end
    host_drv = 1'b1; repeat (OVS) @(negedge clk);
  endtask

  task automatic send_ins(input logic [1:0] op, input logic dev, input logic [1:0] bank,
                          input logic [2:0] n, input logic [7:0] off);
    send_byte({op, dev, bank, n});
    send_byte(off);
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit ok);
    int t;
    ok = 1'b0; b = 8'h00; t = 0;
    while (line !== 1'b0 && t < 40*OVS) begin @(negedge clk); t++; end
    if (line !== 1'b0) return;
    repeat (OVS/2) @(negedge clk);
    if (line !== 1'b0) return;
    for (int i = 0; i < 8; i++) begin repeat (OVS) @(negedge clk); b[i] = line; end
    repeat (OVS) @(negedge clk);
    ok = (line === 1'b1);
  endtask

  task automatic wr1(input logic [1:0] bank, input logic [7:0] off, input logic [7:0] v);
    send_ins(2'b00, 1'b0, bank, 3'd0, off);
    send_byte(v);
    repeat (OVS) @(negedge clk);
  endtask

  task automatic rd1(input logic [1:0] bank, input logic [7:0] off, output logic [7:0] v);
    logic [7:0] b; bit ok;
    send_ins(2'b01, 1'b0, bank, 3'd0, off);
    recv_byte(b, ok);
    v = ok ? b : 8'hxx;
    repeat (2*OVS) @(negedge clk);
  endtask

  function automatic logic [7:0] crc_bit(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] v, b, crc;
    logic [7:0] exp_b [7];
    bit ok;
    int d0;
    repeat (5) @(negedge clk);
    chk("R13 pull_low", {31'b0, pull_low}, 32'd0);
    chk("R13 sleep_req", {31'b0, sleep_req}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13 challenge", challenge, 32'd0);
    chk("R13 sec_sel", {24'b0, sec_sel}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      wr1(VEC[i][25:24], VEC[i][23:16], VEC[i][15:8]);
      rd1(VEC[i][25:24], VEC[i][23:16], v);
      chk("R1 R3 R4 R7 vector", {24'b0, v}, {24'b0, VEC[i][7:0]});
    end

    send_ins(2'b00, 1'b0, 2'd2, 3'd3, 8'd1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    repeat (OVS) @(negedge clk);
    chk("R2 R3 burst write", challenge, 32'h44332211);

    exp_b = '{8'h5A, 8'h11, 8'h22, 8'h33, 8'h44, AUTH, 8'h00};
    crc = 8'h00;
    for (int i = 0; i < 6; i++) crc = crc_bit(crc, exp_b[i]);
    exp_b[6] = crc;
    send_ins(2'b10, 1'b0, 2'd2, 3'd5, 8'd0);
    for (int i = 0; i < 7; i++) begin
      recv_byte(b, ok);
      chk(i == 6 ? "R5 crc byte" : "R4 burst read", {23'b0, ok, b}, {24'h000001, exp_b[i]});
    end
    repeat (2*OVS) @(negedge clk);

    d0 = drv_cnt;
    send_ins(2'b00, 1'b1, 2'd2, 3'd0, 8'd0);
    send_byte(8'hEE);
    send_ins(2'b10, 1'b1, 2'd2, 3'd1, 8'd1);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    repeat (2*OVS) @(negedge clk);
    chk("R6 never drives", drv_cnt - d0, 32'd0);
    rd1(2'd2, 8'd0, v);
    chk("R6 unchanged and aligned", {24'b0, v}, 32'h5A);

    d0 = drv_cnt;
    send_ins(2'b01, 1'b0, 2'd3, 3'd0, 8'd0);
    repeat (40*OVS) @(negedge clk);
    chk("R8 no response", drv_cnt - d0, 32'd0);
    rd1(2'd1, 8'd1, v);
    chk("R9 error latched", {24'b0, v}, 32'h01);
    rd1(2'd1, 8'd1, v);
    chk("R9 cleared by read", {24'b0, v}, 32'h00);
    test_mode = 1'b1;
    rd1(2'd3, 8'd2, v);
    chk("R8 test bank read", {24'b0, v}, 32'h00);
    test_mode = 1'b0;
    rd1(2'd1, 8'd1, v);
    chk("R8 no error in test mode", {24'b0, v}, 32'h00);

    repeat (IDLE_TO + 200) @(negedge clk);
    chk("R10 sleep after idle", {31'b0, sleep_req}, 32'd1);
    host_drv = 1'b0; repeat (2) @(negedge clk); host_drv = 1'b1;
    repeat (20) @(negedge clk);
    chk("R12 glitch ignored", {31'b0, sleep_req}, 32'd1);
    rd1(2'd1, 8'd0, v);
    chk("R12 read after glitch", {24'b0, v}, 32'h41);
    chk("R10 activity drops sleep", {31'b0, sleep_req}, 32'd0);
    wr1(2'd1, 8'd0, 8'h40);
    repeat (IDLE_TO + 200) @(negedge clk);
    chk("R10 disabled no sleep", {31'b0, sleep_req}, 32'd0);

    wr1(2'd3, 8'd0, 8'h00);
    wr1(2'd1, 8'd0, 8'h80);
    rd1(2'd1, 8'd0, v);
    chk("R11 control after soft reset", {24'b0, v}, 32'h01);
    chk("R11 challenge cleared", challenge, 32'd0);
    rd1(2'd1, 8'd1, v);
    chk("R11 error cleared", {24'b0, v}, 32'h00);
    repeat (IDLE_TO + 200) @(negedge clk);
    chk("R11 sleep re-enabled", {31'b0, sleep_req}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule